// File: doc/BRIEF.md
# UART Baud and Oversample Tick Generator

This block turns the UART master clock into two single-cycle strobes. The bit-rate strobe marks each bit period. The oversample strobe feeds the receiver's sampling logic. The division ratio is M × (D + 2), where D is a 16-bit divisor field. The multiplier M is set by two mode bits in a 32-bit control register, in one of three ways: a fixed 16, a programmable prescale of E + 1 taken from a 4-bit field E, or a direct divide by one.

Each mode has its own minimum setting. When IrDA framing is active, only the fixed-16 mode is allowed. If the programmed values break a rule, the block falls back to M = 16, keeps D as programmed, and raises a sticky error flag. A write to the register restarts the count, so the new rate applies from the next clock onwards. The oversample strobe runs only while the effective M is 16, at clock / (D + 2). Every sixteenth oversample strobe coincides with a bit-rate strobe.

Top module: `uart_baud_gen`

## Requirements
- R1: After reset, the register reads 0x0F00_0000 and the error flag is 0.
- R2: A write stores the data with bits 31:30 and 23:16 forced to 0, and the stored value reads back on `cfg_rdata` from the following cycle.
- R3: With bit 29 = 0, M = 16. The first bit strobe comes 16 × (D + 2) cycles after the write edge, and later strobes repeat at that interval. D is held in bits 15:0.
- R4: The oversample strobe pulses 16 times per bit period when the effective M is 16, and never pulses otherwise. The last of those 16 pulses coincides with the bit strobe.
- R5: With bit 29 = 1, bit 28 = 0 and E ≥ 8, the bit period is (E + 1) × (D + 2). E is held in bits 27:24.
- R6: With bits 29 and 28 both 1 and D ≥ 3, the bit period is D + 2.
- R7: Prescale mode with E < 8, or divide-by-one mode with D < 3, sets the error flag and falls back to a period of 16 × (D + 2).
- R8: While `irda_mode` is 1, any setting with bit 29 = 1 sets the error flag and falls back to M = 16. With bit 29 = 0, IrDA mode raises no error.
- R9: The error flag stays at 1 until reset, even after a legal value is written.
- R10: A write restarts both counters. No bit strobe occurs in the cycle after a write, and the count phase that existed before the write has no effect.
- R11: A bit strobe is never followed by another bit strobe in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | UART master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Register write data |
| irda_mode | input | 1 | IrDA framing active; only M = 16 is legal |
| cfg_rdata | output | 32 | Register readback |
| baud_tick | output | 1 | One-cycle bit-rate strobe |
| ovs_tick | output | 1 | One-cycle oversample strobe, running while M = 16 |
| cfg_err | output | 1 | Sticky flag for an illegal setting |

## Verification
The properties assume that `irda_mode` and the register change only on clock edges, and that a write strobe lasts one cycle or more with its data stable. The legality rule in the checker is judged against the register readback and the live `irda_mode` value. The stimulus therefore drives every input at the falling edge and holds each write for exactly one cycle. It leaves `irda_mode` fixed while a period is being measured, so that every measured interval belongs to a single effective mode.

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int BRD_W          = 16,
  parameter int EXT_W          = 4,
  parameter int FIXED_M        = 16,
  parameter int EXT_MIN        = 8,
  parameter int BRD_MIN_DIRECT = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  input  logic        irda_mode,
  output logic [31:0] cfg_rdata,
  output logic        baud_tick,
  output logic        ovs_tick,
  output logic        cfg_err
);
  localparam logic [31:0] RESET_VAL = 32'h0F00_0000;
  localparam logic [31:0] WMASK     = 32'h3F00_FFFF;
  localparam int XEN_BIT = 29;
  localparam int ONE_BIT = 28;
  localparam int EXT_LSB = 24;
  localparam int CNT_W   = BRD_W + 1;
  localparam int M_W     = EXT_W;
  localparam logic [M_W-1:0] M16_LIM = M_W'(FIXED_M - 1);

  logic [31:0]      cfg;
  logic [CNT_W-1:0] d_cnt;
  logic [M_W-1:0]   m_cnt;
  logic             err_q;

  wire             xen  = cfg[XEN_BIT];
  wire             one  = cfg[ONE_BIT];
  wire [EXT_W-1:0] ext  = cfg[EXT_LSB +: EXT_W];
  wire [BRD_W-1:0] brd  = cfg[BRD_W-1:0];

  wire legal   = !xen || (!irda_mode &&
                 (one ? (brd >= BRD_W'(BRD_MIN_DIRECT)) : (ext >= EXT_W'(EXT_MIN))));
  wire use_m16 = !legal || !xen;

  wire [M_W-1:0]   m_lim = use_m16 ? M16_LIM : (one ? '0 : ext);
  wire [CNT_W-1:0] d_lim = {1'b0, brd} + CNT_W'(1);
  wire             d_end = d_cnt >= d_lim;
  wire             m_end = m_cnt >= m_lim;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg   <= RESET_VAL;
      d_cnt <= '0;
      m_cnt <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= err_q | !legal;
      if (cfg_we) begin
        cfg   <= cfg_wdata & WMASK;
        d_cnt <= '0;
        m_cnt <= '0;
      end else begin
        d_cnt <= d_end ? '0 : d_cnt + CNT_W'(1);
        if (d_end) m_cnt <= m_end ? '0 : m_cnt + M_W'(1);
      end
    end
  end

  assign cfg_rdata = cfg;
  assign baud_tick = d_end && m_end;
  assign ovs_tick  = d_end && use_m16;
  assign cfg_err   = err_q;
endmodule

module uart_baud_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [31:0] cfg_wdata,
  input logic        irda_mode,
  input logic [31:0] cfg_rdata,
  input logic        baud_tick,
  input logic        ovs_tick,
  input logic        cfg_err
);
  wire bad = cfg_rdata[29] && (irda_mode ||
             (cfg_rdata[28] ? (cfg_rdata[15:0] < 16'd3) : (cfg_rdata[27:24] < 4'd8)));
  wire m16 = !cfg_rdata[29] || bad;

  assert_write_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata == ($past(cfg_wdata) & 32'h3F00_FFFF));
  assert_ovs_only_m16_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ovs_tick |-> m16);
  assert_baud_on_ovs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_tick && m16) |-> ovs_tick);
  assert_bad_sets_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> cfg_err);
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
  assert_restart_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !baud_tick);
  assert_no_back_to_back_R11: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |=> !baud_tick);
endmodule

bind uart_baud_gen uart_baud_gen_chk u_chk (.*);

// File: tb/tb_uart_baud_gen.sv
module tb_uart_baud_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [31:0] cfg_wdata = '0;
  logic        irda_mode = 0;
  logic [31:0] cfg_rdata;
  logic        baud_tick, ovs_tick, cfg_err;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  uart_baud_gen dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic wr(input logic [31:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(posedge clk); #1 cfg_we = 0;
  endtask

  task automatic measure(input int p, input bit m16, input string req);
    int k = 0, n_ovs = 0;
    bit seen = 0;
    while (!seen && k < p + 10) begin
      @(negedge clk); k++;
      if (ovs_tick) n_ovs++;
      if (baud_tick) seen = 1;
    end
    check(k == p, req, k, p);
    check(n_ovs == (m16 ? 16 : 0), {req, "/R4 ovs"}, n_ovs, m16 ? 16 : 0);
    k = 0; seen = 0;
    while (!seen && k < p + 10) begin
      @(negedge clk); k++;
      if (baud_tick) begin
        seen = 1;
        check(k == 1 || !m16 || ovs_tick, "R4 coincide", ovs_tick, 1);
      end
    end
    check(k == p, {req, " repeat"}, k, p);
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    check(cfg_rdata == 32'h0F00_0000, "R1 reset value", cfg_rdata, 32'h0F00_0000);
    check(cfg_err == 0, "R1 reset err", cfg_err, 0);
  endtask

  task automatic t_fixed();
    wr(32'h0F00_0000); measure(32, 1, "R3 D=0");
    wr(32'h0000_0005); measure(112, 1, "R3 D=5");
    check(cfg_err == 0, "R3 no err", cfg_err, 0);
  endtask

  task automatic t_prescale();
    wr(32'h2800_0002); measure(36, 0, "R5 E=8 D=2");
    wr(32'h2F00_0000); measure(32, 0, "R5 E=15 D=0");
    check(cfg_err == 0, "R5 no err", cfg_err, 0);
  endtask

  task automatic t_direct();
    wr(32'h3000_0003); measure(5, 0, "R6 D=3");
    wr(32'h3000_000A); measure(12, 0, "R6 D=10");
    check(cfg_err == 0, "R6 no err", cfg_err, 0);
  endtask

  task automatic t_illegal();
    do_reset();
    wr(32'h2700_0001); measure(48, 1, "R7 E=7 fallback");
    check(cfg_err == 1, "R7 err E<8", cfg_err, 1);
    wr(32'h0000_0001); @(negedge clk);
    check(cfg_err == 1, "R9 sticky", cfg_err, 1);
    do_reset();
    wr(32'h3000_0002); measure(64, 1, "R7 D=2 fallback");
    check(cfg_err == 1, "R7 err D<3", cfg_err, 1);
  endtask

  task automatic t_irda();
    do_reset();
    irda_mode = 1;
    wr(32'h0000_0003); measure(80, 1, "R8 irda fixed");
    check(cfg_err == 0, "R8 irda fixed no err", cfg_err, 0);
    wr(32'h3000_0003); measure(80, 1, "R8 irda fallback");
    check(cfg_err == 1, "R8 irda err", cfg_err, 1);
    irda_mode = 0;
    do_reset();
  endtask

  task automatic t_readback();
    wr(32'hFFFF_FFFF); @(negedge clk);
    check(cfg_rdata == 32'h3F00_FFFF, "R2 reserved zero", cfg_rdata, 32'h3F00_FFFF);
    wr(32'h1A5A_1234); @(negedge clk);
    check(cfg_rdata == 32'h1A00_1234, "R2 store", cfg_rdata, 32'h1A00_1234);
  endtask

  task automatic t_restart();
    wr(32'h3000_0008);
    repeat (7) @(negedge clk);
    wr(32'h3000_0008);
    measure(10, 0, "R10 restart phase");
  endtask

  initial begin
    t_reset();
    t_fixed();
    t_prescale();
    t_direct();
    t_readback();
    t_restart();
    t_illegal();
    t_irda();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule